// File: doc/BRIEF.md
# Four-Point Inverse Sine Transform Datapath

This block applies a four-point inverse asymmetric discrete sine transform to a vector of four signed 16-bit samples. It produces four signed 16-bit results. Each result is a weighted combination of the inputs formed from four fixed 14-bit sine weights. All partial sums are kept at 32 bits. Each output is then rounded, shifted right by 14 and clamped to the 16-bit range.

The block sits inside a two-dimensional transform engine as one of two interchangeable one-dimensional kernels. The other kernel is a four-point inverse cosine transform with the same interface: one valid strobe and four packed lanes in each direction. Because the two kernels have the same latency, a selector can route vectors to either one without retiming. The block accepts one vector on every cycle in which the strobe is high. Results leave in the same order three cycles later.

Top module: `adst4_inv`

## Requirements
- R1: While reset is asserted, and after it is released with no input accepted, `outValid` is 0 and `outVec` is all zeros.
- R2: A vector presented with `inValid` high at a rising edge produces `outValid` high exactly three rising edges later. `outValid` is low in any cycle that does not correspond to an accepted vector. Vectors on consecutive cycles give results on consecutive cycles, in order.
- R3: Lane k of each vector occupies bits [16k+15:16k], and x0..x3 denote the signed input lanes. The weights are C1=5283, C2=9929, C3=13377 and C4=15212. Output lane 0 is Q(C1*x0 + C4*x2 + C2*x3 + C3*x1).
- R4: Output lane 1 is Q(C2*x0 - C1*x2 - C4*x3 + C3*x1).
- R5: Output lane 2 is Q(C3*(x0 - x2 + x3)). The sum x0 - x2 + x3 is formed at 32 bits, after sign extension.
- R6: Output lane 3 is Q((C1*x0 + C4*x2 + C2*x3) + (C2*x0 - C1*x2 - C4*x3) - C3*x1).
- R7: Q(v) adds 8192 to the 32-bit value v and shifts right arithmetically by 14. Exact halves therefore round toward positive infinity. For example, a lane-2 sum of 13377*8192 gives 6689, and 13377*(-8192) gives -6688.
- R8: Q saturates its result: values above 32767 give 32767 and values below -32768 give -32768.
- R9: While `outValid` is low, `outVec` keeps its last value, whatever is applied on `inVec`.
- R10: An all-zero input vector gives an all-zero output vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input vector strobe |
| inVec | input | 64 | Four signed 16-bit input lanes, lane k at [16k+15:16k] |
| outValid | output | 1 | Result vector strobe |
| outVec | output | 64 | Four signed 16-bit result lanes, lane k at [16k+15:16k] |

## Verification
Single-lane impulses show which weight reaches which output lane, so a swapped weight or a swapped operand shows up at once. Mixed-sign vectors exercise the subtractive terms and the shared term in lanes 0, 1 and 3.

Inputs at full scale of both signs drive every lane into positive and negative clamping. Exact-half values on lane 2 separate rounding toward positive infinity from truncation and from rounding away from zero.

A burst of back-to-back vectors, followed by idle cycles with garbage on the input, separates correct in-order streaming from stale or leaking output data.

// File: rtl/adst4_pkg.sv
package adst4_pkg;
  // Fixed-point sine weights (14-bit fraction), indices 1..4 of 9.
  localparam int SIN1 = 5283;
  localparam int SIN2 = 9929;
  localparam int SIN3 = 13377;
  localparam int SIN4 = 15212;

  // Pipeline depth shared with the cosine kernel.
  localparam int STAGES = 3;

  // Stage-load strobes from the control to the datapath.
  typedef struct packed {
    logic ldProd;   // capture partial products
    logic ldSum;    // capture pre-round sums
    logic ldOut;    // capture rounded, clamped outputs
  } adstCtrl_t;
endpackage

// File: rtl/adst4_ctrl.sv
module adst4_ctrl
  import adst4_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output adstCtrl_t ctrl,
  output logic      outValid
);
  logic [STAGES-1:0] vldPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vldPipe <= '0;
    else       vldPipe <= {vldPipe[STAGES-2:0], inValid};
  end

  always_comb begin
    ctrl.ldProd = inValid;
    ctrl.ldSum  = vldPipe[0];
    ctrl.ldOut  = vldPipe[1];
  end

  assign outValid = vldPipe[STAGES-1];
endmodule

// File: rtl/adst4_dp.sv
module adst4_dp
  import adst4_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32,
  parameter int SHIFT  = 14,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  adstCtrl_t               ctrl,
  input  logic [LANES*DATA_W-1:0] inVec,
  output logic [LANES*DATA_W-1:0] outVec
);
  localparam int SH_W = ACC_W - SHIFT + 1;
  localparam logic signed [ACC_W-1:0] K1 = ACC_W'(SIN1);
  localparam logic signed [ACC_W-1:0] K2 = ACC_W'(SIN2);
  localparam logic signed [ACC_W-1:0] K3 = ACC_W'(SIN3);
  localparam logic signed [ACC_W-1:0] K4 = ACC_W'(SIN4);
  localparam logic signed [ACC_W:0]   RND = (ACC_W+1)'(1) << (SHIFT-1);
  localparam logic signed [SH_W-1:0]  SAT_HI = SH_W'((2**(DATA_W-1)) - 1);
  localparam logic signed [SH_W-1:0]  SAT_LO = -SH_W'(2**(DATA_W-1));

  logic signed [ACC_W-1:0] xExt [LANES];

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : gUnpack
      assign xExt[g] = {{(ACC_W-DATA_W){inVec[g*DATA_W+DATA_W-1]}},
                        inVec[g*DATA_W +: DATA_W]};
    end
  endgenerate

  // Stage 1: partial products and combined input term.
  logic signed [ACC_W-1:0] p0, p1, p2, p3, p4, p5, p6, p7;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {p0, p1, p2, p3, p4, p5, p6, p7} <= '0;
    end else if (ctrl.ldProd) begin
      p0 <= K1 * xExt[0];
      p1 <= K2 * xExt[0];
      p2 <= K3 * xExt[1];
      p3 <= K4 * xExt[2];
      p4 <= K1 * xExt[2];
      p5 <= K2 * xExt[3];
      p6 <= K4 * xExt[3];
      p7 <= xExt[0] + xExt[3] - xExt[2];
    end
  end

  // Stage 2: intermediates and pre-round outputs (modulo 2^ACC_W).
  logic signed [ACC_W-1:0] termA, termB, termC;
  logic signed [ACC_W-1:0] preSum [LANES];
  assign termA = p0 + p3 + p5;
  assign termB = p1 - p4 - p6;
  assign termC = K3 * p7;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LANES; i++) preSum[i] <= '0;
    end else if (ctrl.ldSum) begin
      preSum[0] <= termA + p2;
      preSum[1] <= termB + p2;
      preSum[2] <= termC;
      preSum[3] <= termA + termB - p2;
    end
  end

  // Stage 3: round, shift, clamp per lane.
  generate
    for (g = 0; g < LANES; g++) begin : gRound
      logic signed [ACC_W:0]    rounded;
      logic signed [SH_W-1:0]   shifted;
      logic        [DATA_W-1:0] clamped;
      logic        [DATA_W-1:0] laneReg;

      assign rounded = {preSum[g][ACC_W-1], preSum[g]} + RND;
      assign shifted = $signed(rounded[ACC_W:SHIFT]);

      always_comb begin
        if (shifted > SAT_HI)      clamped = SAT_HI[DATA_W-1:0];
        else if (shifted < SAT_LO) clamped = SAT_LO[DATA_W-1:0];
        else                       clamped = shifted[DATA_W-1:0];
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          laneReg <= '0;
        else if (ctrl.ldOut) laneReg <= clamped;
      end

      assign outVec[g*DATA_W +: DATA_W] = laneReg;
    end
  endgenerate
endmodule

// File: rtl/adst4_inv.sv
module adst4_inv
  import adst4_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32,
  parameter int SHIFT  = 14
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [4*DATA_W-1:0] inVec,
  output logic            outValid,
  output logic [4*DATA_W-1:0] outVec
);
  adstCtrl_t ctrl;

  adst4_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  adst4_dp #(
    .DATA_W (DATA_W),
    .ACC_W  (ACC_W),
    .SHIFT  (SHIFT),
    .LANES  (4)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .inVec  (inVec),
    .outVec (outVec)
  );
endmodule

// File: rtl/adst4_inv_chk.sv
module adst4_inv_chk #(
  parameter int VEC_W = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [VEC_W-1:0] inVec,
  input logic             outValid,
  input logic [VEC_W-1:0] outVec
);
  // R1: idle, cleared outputs while reset is held
  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_idle_R1: assert (!outValid && outVec == '0)
        else $error("reset state violated");
    end
  end

  // R2: accepted vector yields a result three edges later
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##3 outValid);

  // R2: no result without a matching accepted vector
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##3 !outValid);

  // R9: outputs frozen while no result is presented
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outVec));

  // R10: zero in, zero out
  assert_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inVec == '0) |-> ##3 (outVec == '0));
endmodule

bind adst4_inv adst4_inv_chk #(.VEC_W(4*DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inVec    (inVec),
  .outValid (outValid),
  .outVec   (outVec)
);

// File: tb/test_adst4_inv.sv
module test_adst4_inv;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] inVec = '0;
  logic        outValid;
  logic [63:0] outVec;

  int checks = 0;
  int failures = 0;

  adst4_inv i_adst4_inv (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inVec    (inVec),
    .outValid (outValid),
    .outVec   (outVec)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] qRound(input int v);
    longint r;
    r = (longint'(v) + 64'sd8192) >>> 14;
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return r[15:0];
  endfunction

  function automatic logic [63:0] model(input logic [63:0] v);
    int x0, x1, x2, x3, a, b, c, d;
    x0 = int'($signed(v[15:0]));
    x1 = int'($signed(v[31:16]));
    x2 = int'($signed(v[47:32]));
    x3 = int'($signed(v[63:48]));
    a = 5283*x0 + 15212*x2 + 9929*x3;
    b = 9929*x0 - 5283*x2 - 15212*x3;
    c = 13377*(x0 - x2 + x3);
    d = 13377*x1;
    return {qRound(a + b - d), qRound(c), qRound(b + d), qRound(a + d)};
  endfunction

  function automatic logic [63:0] pack4(input int x0, input int x1,
                                        input int x2, input int x3);
    return {x3[15:0], x2[15:0], x1[15:0], x0[15:0]};
  endfunction

  task automatic checkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic checkLanes(input logic [63:0] act, input logic [63:0] exp);
    string tags[4] = '{"R3", "R4", "R5", "R6"};
    for (int k = 0; k < 4; k++) begin
      checks++;
      if (act[16*k +: 16] !== exp[16*k +: 16]) begin
        failures++;
        $display("FAIL %s lane%0d: actual=%0d expected=%0d", tags[k], k,
                 $signed(act[16*k +: 16]), $signed(exp[16*k +: 16]));
      end
    end
  endtask

  task automatic checkWord(input string req, input logic [15:0] act,
                           input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, $signed(act), $signed(exp));
    end
  endtask

  // Push one vector and check it at the third edge (R2 timing).
  task automatic runOne(input logic [63:0] v, output logic [63:0] res);
    @(negedge clk);
    inValid = 1'b1; inVec = v;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    checkBit("R2 early", outValid, 1'b0);
    @(negedge clk);
    checkBit("R2 valid", outValid, 1'b1);
    res = outVec;
    checkLanes(outVec, model(v));
  endtask

  task automatic testReset();
    logic [63:0] dummy;
    checkBit("R1 valid", outValid, 1'b0);
    checks++;
    if (outVec !== '0) begin
      failures++;
      $display("FAIL R1: actual=%h expected=0", outVec);
    end
    dummy = '0;
  endtask

  task automatic testImpulses();
    logic [63:0] r;
    for (int k = 0; k < 4; k++) begin
      runOne(64'(16'd1000) << (16*k), r);
      runOne(64'(16'hFC18) << (16*k), r);
    end
  endtask

  task automatic testMixed();
    logic [63:0] r;
    runOne(pack4(1234, -2345, 3456, -4567), r);
    runOne(pack4(-7000, 12000, -300, 9999), r);
    runOne(pack4(20000, 20000, 20000, 20000), r);
  endtask

  task automatic testZero();
    logic [63:0] r;
    runOne('0, r);
    checks++;
    if (r !== '0) begin
      failures++;
      $display("FAIL R10: actual=%h expected=0", r);
    end
  endtask

  task automatic testSaturation();
    logic [63:0] r;
    runOne(pack4(32767, 32767, 0, 32767), r);
    checkWord("R8 hi lane0", r[15:0], 16'sd32767);
    runOne(pack4(-32768, -32768, 0, -32768), r);
    checkWord("R8 lo lane0", r[15:0], 16'h8000);
    runOne(pack4(32767, -32768, -32768, 32767), r);
  endtask

  task automatic testRounding();
    logic [63:0] r;
    runOne(pack4(8192, 0, 0, 0), r);
    checkWord("R7 tie pos", r[47:32], 16'sd6689);
    runOne(pack4(-8192, 0, 0, 0), r);
    checkWord("R7 tie neg", r[47:32], -16'sd6688);
  endtask

  task automatic testBurst();
    logic [63:0] vecs[4];
    vecs[0] = pack4(100, 200, 300, 400);
    vecs[1] = pack4(-500, 600, -700, 800);
    vecs[2] = pack4(30000, -30000, 15000, -15000);
    vecs[3] = pack4(1, -1, 1, -1);
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (i >= 3 && i < 7) begin
        checkBit("R2 burst", outValid, 1'b1);
        checkLanes(outVec, model(vecs[i-3]));
      end else if (i == 7) begin
        checkBit("R2 burst end", outValid, 1'b0);
      end
      if (i < 4) begin
        inValid = 1'b1; inVec = vecs[i];
      end else begin
        inValid = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  task automatic testHold();
    logic [63:0] r;
    runOne(pack4(4321, -1234, 777, -888), r);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      inVec = {16'(i*37+5), 16'hA5A5, 16'(i*911), 16'h7FFF};
      checkBit("R9 valid", outValid, 1'b0);
      checks++;
      if (outVec !== r) begin
        failures++;
        $display("FAIL R9: actual=%h expected=%h", outVec, r);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testImpulses();
    testMixed();
    testZero();
    testSaturation();
    testRounding();
    testBurst();
    testHold();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule